// File: doc/BRIEF.md
# Powered-Down Peripheral Access Trap

This block sits beside the CPU's I/O cycle decode and decides whether an I/O access aimed at a peripheral that may be asleep should be intercepted by a system-management interrupt. It serves a small set of timer-controlled devices, three by default. Each device has two register bits, reached over a simple indexed register port. The first is an idle bit that is 1 while the device is taken to be powered and 0 once it is taken to be asleep. The second is an enable bit that allows trapping for that device.

An external inactivity timer pulses `idle_tmo[n]` to mark device n asleep. Firmware can also write a 0 to an idle bit, so that the next access to that device traps even if no timeout has occurred. Writing a 1 marks the device powered again.

A qualifying access produces a one-cycle `trap_req` in the same cycle as the I/O strobe. It also sets a sticky cause bit, which software clears by writing 1 to it. A small arming state machine controls when traps may fire:

- **ST_RUN (armed):** traps may fire.
  - A trap moves it to ST_WAIT.
  - `in_smi` high moves it to ST_SMI.
- **ST_WAIT:** a trap has been raised and the handler has not yet started. Further traps are held off.
  - `in_smi` high moves it to ST_SMI.
- **ST_SMI (handler running):** traps are held off.
  - `in_smi` low moves it back to ST_RUN.

A trap is never replayed when the handler ends. Only its status bit remains set.

Top module: `iotrap_top`

## Requirements
- R1: After reset, all idle bits read 1, all enable bits read 0, all status bits read 0, and `trap_req` is 0.
- R2: A write to index `IDX_IDLE` (10h) or `IDX_EN` (11h) loads bit n of the write data into that register's bit n, and a read of the same index returns the stored value on `reg_rdata` in the same cycle.
- R3: A pulse on `idle_tmo[n]` clears idle bit n at the next edge. When it coincides with a write of 1 to that bit, the pulse wins.
- R4: `trap_req` is 1 in the strobe cycle when all of the following hold: `io_strobe` is 1, `dev_sel[n]` is 1, idle bit n is 0, enable bit n is 1, the machine is in ST_RUN, and `in_smi` is 0.
- R5: No trap occurs for a selected device whose idle bit is 1 or whose enable bit is 0.
- R6: No trap occurs in any cycle in which `in_smi` is 1, including while in ST_RUN.
- R7: After a trap, no further trap occurs until `in_smi` has been seen high and then low again. After that, a qualifying access traps again.
- R8: A trap sets status bit n for each device that caused it. Writing 1 to a bit at index `IDX_STAT` (12h) clears that bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: When `in_smi` falls, `trap_req` stays 0 even though status bits remain set. Pending trap causes are not replayed.
- R10: A read of any index other than 10h, 11h or 12h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for read and write |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data for `reg_idx` (combinational) |
| io_strobe | input | 1 | One CPU I/O cycle is present |
| dev_sel | input | 3 | Decoded one-hot target device |
| in_smi | input | 1 | CPU is running the SMI handler |
| idle_tmo | input | 3 | Per-device inactivity timeout pulses |
| trap_req | output | 1 | One-cycle trap request |
| trap_status | output | 3 | Sticky per-device trap cause bits |

## Verification
The bench uses the default parameters: three devices, an 8-bit index, and register indices 10h, 11h and 12h. These are enough to separate the two trap gates on different devices. Device 1 is asleep but not enabled, while device 2 is forced asleep by a write, so each gate is exercised on its own. Three bits are also enough to observe the per-bit priority of a timeout pulse over a write. Re-arming is exercised through every state edge, including a trap attempted in ST_WAIT and an `in_smi` pulse seen while in ST_RUN.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SMI  = 2'd2
    } trap_state_e;
endpackage

// File: rtl/iotrap_regs.sv
module iotrap_regs #(
    parameter int NUM_DEV  = 3,
    parameter int IDX_W    = 8,
    parameter logic [IDX_W-1:0] IDX_IDLE = 8'h10,
    parameter logic [IDX_W-1:0] IDX_EN   = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [NUM_DEV-1:0] reg_wdata,
    input  logic [NUM_DEV-1:0] idle_tmo,
    output logic [NUM_DEV-1:0] idle_q,
    output logic [NUM_DEV-1:0] en_q
);
    logic wr_idle;
    logic wr_en;

    assign wr_idle = reg_wr && (reg_idx == IDX_IDLE);
    assign wr_en   = reg_wr && (reg_idx == IDX_EN);

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_idle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idle_q[i] <= 1'b1;
            end else if (idle_tmo[i]) begin
                idle_q[i] <= 1'b0;
            end else if (wr_idle) begin
                idle_q[i] <= reg_wdata[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= reg_wdata;
        end
    end

    // R3: a timeout pulse leaves its idle bit cleared, whatever was written
    a_r3_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|idle_tmo) |=> ((idle_q & $past(idle_tmo)) == '0));

    // R2: enable register holds its value without a write
    a_r2_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));
endmodule

// File: rtl/iotrap_fsm.sv
module iotrap_fsm
    import iotrap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_smi,
    input  logic trap_fire,
    output logic armed
);
    trap_state_e state_q;
    trap_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (in_smi) begin
                    state_d = ST_SMI;
                end else if (trap_fire) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (in_smi) begin
                    state_d = ST_SMI;
                end
            end
            ST_SMI: begin
                if (!in_smi) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        armed = (state_q == ST_RUN);
    end

    // R7: a fired trap leaves the machine disarmed on the next cycle
    a_r7_disarm_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire |=> !armed);

    // R9: the first cycle after the handler ends is never armed
    a_r9_no_replay_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_smi) |-> !armed);
endmodule

// File: rtl/iotrap_status.sv
module iotrap_status #(
    parameter int NUM_DEV = 3,
    parameter int IDX_W   = 8,
    parameter logic [IDX_W-1:0] IDX_STAT = 8'h12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [NUM_DEV-1:0] reg_wdata,
    input  logic [NUM_DEV-1:0] cause_set,
    output logic [NUM_DEV-1:0] status_q
);
    logic [NUM_DEV-1:0] clr_mask;

    assign clr_mask = (reg_wr && (reg_idx == IDX_STAT)) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | cause_set;
        end
    end

    // R8: every recorded cause is visible the cycle after it is set
    a_r8_cause_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_set) |=> ((status_q & $past(cause_set)) == $past(cause_set)));

    // R8: bits not cleared and not set stay put
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask == '0) && (cause_set == '0)) |=> $stable(status_q));
endmodule

// File: rtl/iotrap_top.sv
module iotrap_top #(
    parameter int NUM_DEV = 3,
    parameter int IDX_W   = 8,
    parameter logic [IDX_W-1:0] IDX_IDLE = 8'h10,
    parameter logic [IDX_W-1:0] IDX_EN   = 8'h11,
    parameter logic [IDX_W-1:0] IDX_STAT = 8'h12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [NUM_DEV-1:0] reg_wdata,
    output logic [NUM_DEV-1:0] reg_rdata,
    input  logic               io_strobe,
    input  logic [NUM_DEV-1:0] dev_sel,
    input  logic               in_smi,
    input  logic [NUM_DEV-1:0] idle_tmo,
    output logic               trap_req,
    output logic [NUM_DEV-1:0] trap_status
);
    logic [NUM_DEV-1:0] idle_q;
    logic [NUM_DEV-1:0] en_q;
    logic [NUM_DEV-1:0] hit_vec;
    logic [NUM_DEV-1:0] cause_set;
    logic               armed;
    logic               fire;

    iotrap_regs #(
        .NUM_DEV  (NUM_DEV),
        .IDX_W    (IDX_W),
        .IDX_IDLE (IDX_IDLE),
        .IDX_EN   (IDX_EN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .idle_tmo  (idle_tmo),
        .idle_q    (idle_q),
        .en_q      (en_q)
    );

    iotrap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_smi    (in_smi),
        .trap_fire (fire),
        .armed     (armed)
    );

    iotrap_status #(
        .NUM_DEV  (NUM_DEV),
        .IDX_W    (IDX_W),
        .IDX_STAT (IDX_STAT)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .cause_set (cause_set),
        .status_q  (trap_status)
    );

    assign hit_vec   = dev_sel & ~idle_q & en_q & {NUM_DEV{io_strobe}};
    assign fire      = armed && !in_smi && (|hit_vec);
    assign cause_set = fire ? hit_vec : '0;
    assign trap_req  = fire;

    always_comb begin
        unique case (reg_idx)
            IDX_IDLE: reg_rdata = idle_q;
            IDX_EN:   reg_rdata = en_q;
            IDX_STAT: reg_rdata = trap_status;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: no request while the handler runs
    a_r6_quiet_in_smi: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !in_smi);

    // R4/R5: a request needs a strobe to an asleep, enabled device
    a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (io_strobe && ((dev_sel & ~idle_q & en_q) != '0)));

    // R7: requests are single-cycle pulses
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R1: no request during or straight out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !trap_req);
endmodule

// File: tb/tb_iotrap_top.sv
module tb_iotrap_top;
    localparam int K_TRAP = 0;
    localparam int K_RD   = 1;
    localparam int K_STAT = 2;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_idx = 8'hFF;
    logic [2:0] reg_wdata = '0;
    logic [2:0] reg_rdata;
    logic       io_strobe = 1'b0;
    logic [2:0] dev_sel = '0;
    logic       in_smi = 1'b0;
    logic [2:0] idle_tmo = '0;
    logic       trap_req;
    logic [2:0] trap_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    iotrap_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_idx     (reg_idx),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .io_strobe   (io_strobe),
        .dev_sel     (dev_sel),
        .in_smi      (in_smi),
        .idle_tmo    (idle_tmo),
        .trap_req    (trap_req),
        .trap_status (trap_status)
    );

    task automatic cyc(input logic strb, input logic [2:0] sel, input logic smi,
                       input logic [2:0] idle, input logic wr, input logic [7:0] idx,
                       input logic [2:0] wd);
        @(negedge clk);
        io_strobe = strb;
        dev_sel   = sel;
        in_smi    = smi;
        idle_tmo  = idle;
        reg_wr    = wr;
        reg_idx   = idx;
        reg_wdata = wd;
    endtask

    task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_TRAP:  act = {7'd0, trap_req};
                    K_RD:    act = {5'd0, reg_rdata};
                    default: act = {5'd0, trap_status};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h10, 3'b000);
        expect_item(K_RD, 8'h7, "R1 idle reset");
        expect_item(K_TRAP, 8'h0, "R1 trap reset");
        expect_item(K_STAT, 8'h0, "R1 status reset");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h11, 3'b000);
        expect_item(K_RD, 8'h0, "R1 enable reset");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h12, 3'b000);
        expect_item(K_RD, 8'h0, "R1 status read reset");
        // R2 enable write and read back
        cyc(0, 3'b000, 0, 3'b000, 1, 8'h11, 3'b111);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h11, 3'b000);
        expect_item(K_RD, 8'h7, "R2 enable readback");
        // R10 unused index
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h20, 3'b000);
        expect_item(K_RD, 8'h0, "R10 unused index");
        // R5 device still powered
        cyc(1, 3'b001, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R5 powered device");
        // R3 timeout pulse clears bit 0
        cyc(0, 3'b000, 0, 3'b001, 0, 8'hFF, 3'b000);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h10, 3'b000);
        expect_item(K_RD, 8'h6, "R3 pulse clears");
        // R4 qualifying access traps
        cyc(1, 3'b001, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h1, "R4 trap dev0");
        // R7 held off in wait state
        cyc(1, 3'b001, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R7 no second trap");
        expect_item(K_STAT, 8'h1, "R8 status set dev0");
        // R6 inside handler
        cyc(1, 3'b001, 1, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R6 in handler");
        cyc(1, 3'b001, 1, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R6 in handler again");
        // R9 no replay after handler ends
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R9 exit cycle");
        expect_item(K_STAT, 8'h1, "R9 status kept");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R9 after exit");
        // R3 pulse beats write of 1
        cyc(0, 3'b000, 0, 3'b010, 1, 8'h10, 3'b111);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h10, 3'b000);
        expect_item(K_RD, 8'h5, "R3 pulse over write");
        // R5 asleep but disabled
        cyc(0, 3'b000, 0, 3'b000, 1, 8'h11, 3'b101);
        cyc(1, 3'b010, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R5 disabled device");
        // R2 firmware forces bit 2 asleep
        cyc(0, 3'b000, 0, 3'b000, 1, 8'h10, 3'b011);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h10, 3'b000);
        expect_item(K_RD, 8'h3, "R2 idle write");
        cyc(1, 3'b100, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h1, "R4 forced trap dev2");
        cyc(0, 3'b000, 1, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_STAT, 8'h5, "R8 status accumulates");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        // R8 write-one-to-clear
        cyc(0, 3'b000, 0, 3'b000, 1, 8'h12, 3'b001);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'h12, 3'b000);
        expect_item(K_STAT, 8'h4, "R8 w1c port");
        expect_item(K_RD, 8'h4, "R8 w1c read");
        // R8 set wins over clear
        cyc(1, 3'b100, 0, 3'b000, 1, 8'h12, 3'b100);
        expect_item(K_TRAP, 8'h1, "R4 trap with clear");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_STAT, 8'h4, "R8 set over clear");
        cyc(0, 3'b000, 1, 3'b000, 0, 8'hFF, 3'b000);
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        // R6 handler flag while armed
        cyc(1, 3'b100, 1, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h0, "R6 armed but in handler");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        // R7 re-armed after handler
        cyc(1, 3'b100, 0, 3'b000, 0, 8'hFF, 3'b000);
        expect_item(K_TRAP, 8'h1, "R7 re-armed");
        cyc(0, 3'b000, 0, 3'b000, 0, 8'hFF, 3'b000);
        repeat (2) @(negedge clk);
        #5;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule